// File: doc/BRIEF.md
# Reconfiguration Engine Host Register Block

This block is the host-side register file and session sequencer for a partial-reconfiguration engine. Software reaches it through a 64-bit register port with a write strobe and a combinational read path. Through it, software can request and observe an engine reset, choose a 3-bit target region, open a session, push 32-bit configuration words into an internal queue, and tell the engine that all data has been sent. The engine side has three duties. It drains the queue with a valid/take handshake. It reports a release pulse when the session has finished. It raises error pulses.

Software paces itself by the credit field of the status register, which reports the number of free queue entries. It sends a word only while the credit is above one. Faults are held in sticky flags that survive until software writes ones to them. The 128-bit interface identifier is fixed at elaboration and lets software check that an image is compatible before it programs one.

Top module: `rcfg_ctrl_regs`

## Requirements
- R1: Registers decode at control 0x08, status 0x10, data 0x18, error 0x20, identifier-high 0xA8 and identifier-low 0xB0. Any other offset, and the data offset itself, reads as zero. Writes to the identifier offsets have no effect.
- R2: Control bit 0 holds the reset request. Control bit 4, the acknowledge, reads 1 starting one cycle after the request takes effect. It returns to 0 in the same cycle that a control write clears bit 0, and it is never 1 while bit 0 is 0.
- R3: While the reset request is held, `eng_rst_req` is 1, the queue is emptied (credit returns to DEPTH and `word_valid` goes to 0), and control bits 12 and 13 are cleared.
- R4: A control write stores bits 9:7 as the target region. The region reads back in those bits and drives `eng_region`.
- R5: A control write with bit 12 set opens a session. Writing 0 to bit 12 does not close it. Only an `eng_release` pulse or a reset request clears bit 12. Status bit 16 reads 1 exactly while bit 12 is set.
- R6: A control write with bit 13 set raises the data-complete flag, which drives `eng_pushed`. The flag is cleared together with bit 12.
- R7: Status bits 8:0 give DEPTH minus the queue occupancy. Bits 22:20 mirror `eng_ctrlr_sts`, and bits 27:24 mirror `eng_host_sts`.
- R8: During a session, each data write enqueues bits 31:0 of the write data and ignores bits 63:32. Words leave on `word_data` in the order they were written, and one word leaves per cycle in which `word_take` is 1 and `word_valid` is 1.
- R9: A data write during a session while the queue is full sets error bit 4 (overflow) and discards the word. The queue contents are left unchanged.
- R10: A data write while no session is open sets error bit 3 (protocol) and discards the word.
- R11: Error bits 0, 1 and 2 are set by pulses on `eng_err_op`, `eng_err_crc` and `eng_err_incompat`. All error bits stay set until a write to the error register places a 1 in that bit position. A set in the same cycle as a clear wins.
- R12: The identifier-high offset reads the INTF_ID_HI parameter, and the identifier-low offset reads INTF_ID_LO.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Byte offset of the register access |
| bus_wdata | input | 64 | Write data |
| bus_rdata | output | 64 | Read data for `bus_addr` (combinational) |
| eng_rst_req | output | 1 | Reset request to the engine |
| eng_region | output | 3 | Target region of the session |
| eng_session | output | 1 | Session open (control bit 12) |
| eng_pushed | output | 1 | All data pushed (control bit 13) |
| eng_release | input | 1 | Engine has released its resources; closes the session |
| eng_err_op | input | 1 | Operation error pulse |
| eng_err_crc | input | 1 | CRC error pulse |
| eng_err_incompat | input | 1 | Incompatible image pulse |
| eng_ctrlr_sts | input | 3 | Controller status field |
| eng_host_sts | input | 4 | Host status field |
| word_valid | output | 1 | Queue holds a word |
| word_data | output | WORD_W | Oldest queued word |
| word_take | input | 1 | Engine consumes the oldest word |

## Verification
Several properties are checked on every cycle. The acknowledge is only ever seen together with the request. The session bit falls only after a release or a reset request. A flush leaves no valid word. The queue never holds more than DEPTH entries. Error flags are never lost without a clear, and every detected misuse of the data register raises its flag in the next cycle.

Other behaviour can only be shown by the bench scenarios. These cover word ordering and the discarding of upper bits under random push/take traffic, the exact credit value at each occupancy, leaving the queue contents untouched on overflow, readback of the identifier, the set-beats-clear case, and ignored writes to read-only or unmapped offsets.

// File: rtl/rcfg_pkg.sv
package rcfg_pkg;
   // register byte offsets
   localparam int OFS_CTRL   = 'h08;
   localparam int OFS_STAT   = 'h10;
   localparam int OFS_DATA   = 'h18;
   localparam int OFS_ERR    = 'h20;
   localparam int OFS_ID_HI  = 'hA8;
   localparam int OFS_ID_LO  = 'hB0;
   localparam int SPAN_BYTES = 'hB8;

   // control field positions
   localparam int CTL_RST    = 0;
   localparam int CTL_ACK    = 4;
   localparam int CTL_RGN_LO = 7;
   localparam int RGN_W      = 3;
   localparam int CTL_START  = 12;
   localparam int CTL_DONE   = 13;

   // status field positions
   localparam int STS_CRED_W   = 9;
   localparam int STS_BUSY     = 16;
   localparam int STS_CTRLR_LO = 20;
   localparam int STS_HOST_LO  = 24;

   // error flag positions
   localparam int ERR_OP     = 0;
   localparam int ERR_CRC    = 1;
   localparam int ERR_INCOMP = 2;
   localparam int ERR_PROTO  = 3;
   localparam int ERR_OVF    = 4;
   localparam int ERR_W      = 5;

   typedef logic [63:0] reg64_t;
endpackage

// File: rtl/rcfg_err_flags.sv
module rcfg_err_flags #(
   parameter int W = 5
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] set_i,
   input  logic [W-1:0] clr_i,
   output logic [W-1:0] flag_o
);
   logic [W-1:0] flag_q;

   if (W < 1) begin : g_bad_w
      $error("rcfg_err_flags: W must be at least 1");
   end

   for (genvar i = 0; i < W; i++) begin : g_bit
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)        flag_q[i] <= 1'b0;
         else if (set_i[i]) flag_q[i] <= 1'b1;
         else if (clr_i[i]) flag_q[i] <= 1'b0;
      end

      AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
         set_i[i] |=> flag_q[i]); // R11
   end

   AST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      ((flag_q & ~clr_i) != '0) |=> (($past(flag_q & ~clr_i) & ~flag_q) == '0)); // R11

   assign flag_o = flag_q;
endmodule

// File: rtl/rcfg_word_queue.sv
module rcfg_word_queue #(
   parameter int DEPTH  = 16,
   parameter int WORD_W = 32,
   localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int CNT_W = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              flush_i,
   input  logic              push_i,
   input  logic [WORD_W-1:0] push_data_i,
   input  logic              pop_i,
   output logic [WORD_W-1:0] head_o,
   output logic              empty_o,
   output logic              full_o,
   output logic [CNT_W-1:0]  count_o
);
   logic [WORD_W-1:0] mem_q [DEPTH];
   logic [PTR_W-1:0]  wptr_q, rptr_q;
   logic [CNT_W-1:0]  cnt_q;

   if (DEPTH < 2) begin : g_bad_depth
      $error("rcfg_word_queue: DEPTH must be at least 2");
   end

   function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
      return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
   endfunction

   for (genvar i = 0; i < DEPTH; i++) begin : g_slot
      always_ff @(posedge clk) begin
         if (push_i && !flush_i && wptr_q == PTR_W'(i)) mem_q[i] <= push_data_i;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wptr_q <= '0;
         rptr_q <= '0;
         cnt_q  <= '0;
      end else if (flush_i) begin
         wptr_q <= '0;
         rptr_q <= '0;
         cnt_q  <= '0;
      end else begin
         if (push_i) wptr_q <= nxt(wptr_q);
         if (pop_i)  rptr_q <= nxt(rptr_q);
         if (push_i && !pop_i)      cnt_q <= cnt_q + 1'b1;
         else if (pop_i && !push_i) cnt_q <= cnt_q - 1'b1;
      end
   end

   assign head_o  = mem_q[rptr_q];
   assign empty_o = (cnt_q == '0);
   assign full_o  = (cnt_q == CNT_W'(DEPTH));
   assign count_o = cnt_q;

   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= CNT_W'(DEPTH)); // R7
   AST_PUSH_ROOM: assert property (@(posedge clk) disable iff (!rst_n)
      (push_i && !pop_i) |-> !full_o); // R9
   AST_POP_DATA: assert property (@(posedge clk) disable iff (!rst_n)
      pop_i |-> !empty_o); // R8
endmodule

// File: rtl/rcfg_ctrl_regs.sv
module rcfg_ctrl_regs
   import rcfg_pkg::*;
#(
   parameter int          ADDR_W     = 8,
   parameter int          DEPTH      = 16,
   parameter int          WORD_W     = 32,
   parameter logic [63:0] INTF_ID_HI = 64'h5A17_C0DE_0000_0001,
   parameter logic [63:0] INTF_ID_LO = 64'h9E3D_44F1_BEEF_7702
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [63:0]       bus_wdata,
   output logic [63:0]       bus_rdata,
   output logic              eng_rst_req,
   output logic [2:0]        eng_region,
   output logic              eng_session,
   output logic              eng_pushed,
   input  logic              eng_release,
   input  logic              eng_err_op,
   input  logic              eng_err_crc,
   input  logic              eng_err_incompat,
   input  logic [2:0]        eng_ctrlr_sts,
   input  logic [3:0]        eng_host_sts,
   output logic              word_valid,
   output logic [WORD_W-1:0] word_data,
   input  logic              word_take
);
   localparam int CNT_W = $clog2(DEPTH + 1);

   if (DEPTH >= (1 << STS_CRED_W)) begin : g_bad_depth
      $error("rcfg_ctrl_regs: DEPTH does not fit the credit field");
   end
   if (WORD_W < 1 || WORD_W > 32) begin : g_bad_word
      $error("rcfg_ctrl_regs: WORD_W must be 1..32");
   end
   if ((1 << ADDR_W) < SPAN_BYTES) begin : g_bad_addr
      $error("rcfg_ctrl_regs: ADDR_W too narrow for the register span");
   end

   logic             rst_req_q, ack_q, start_q, done_q;
   logic [RGN_W-1:0] region_q;
   logic             wr_ctrl, wr_data, wr_err;
   logic             q_empty, q_full, q_push, q_pop;
   logic [CNT_W-1:0] q_count;
   logic [STS_CRED_W-1:0] credit;
   logic [ERR_W-1:0] err_set, err_clr, err_q;
   reg64_t           ctrl_rd, stat_rd;
   logic             unused_wdata;

   assign wr_ctrl = bus_wr && (bus_addr == ADDR_W'(OFS_CTRL));
   assign wr_data = bus_wr && (bus_addr == ADDR_W'(OFS_DATA));
   assign wr_err  = bus_wr && (bus_addr == ADDR_W'(OFS_ERR));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rst_req_q <= 1'b0;
         ack_q     <= 1'b0;
         start_q   <= 1'b0;
         done_q    <= 1'b0;
         region_q  <= '0;
      end else begin
         if (wr_ctrl) begin
            rst_req_q <= bus_wdata[CTL_RST];
            region_q  <= bus_wdata[CTL_RGN_LO +: RGN_W];
         end
         if (wr_ctrl && !bus_wdata[CTL_RST]) ack_q <= 1'b0;
         else                                ack_q <= rst_req_q;
         if (rst_req_q || eng_release) begin
            start_q <= 1'b0;
            done_q  <= 1'b0;
         end else begin
            if (wr_ctrl && bus_wdata[CTL_START]) start_q <= 1'b1;
            if (wr_ctrl && bus_wdata[CTL_DONE])  done_q  <= 1'b1;
         end
      end
   end

   assign q_push = wr_data && start_q && !rst_req_q && !q_full;
   assign q_pop  = word_take && !q_empty;

   rcfg_word_queue #(.DEPTH(DEPTH), .WORD_W(WORD_W)) u_queue (
      .clk         (clk),
      .rst_n       (rst_n),
      .flush_i     (rst_req_q),
      .push_i      (q_push),
      .push_data_i (bus_wdata[WORD_W-1:0]),
      .pop_i       (q_pop),
      .head_o      (word_data),
      .empty_o     (q_empty),
      .full_o      (q_full),
      .count_o     (q_count)
   );

   assign credit = STS_CRED_W'(DEPTH) - STS_CRED_W'(q_count);

   always_comb begin
      err_set             = '0;
      err_set[ERR_OP]     = eng_err_op;
      err_set[ERR_CRC]    = eng_err_crc;
      err_set[ERR_INCOMP] = eng_err_incompat;
      err_set[ERR_PROTO]  = wr_data && !start_q;
      err_set[ERR_OVF]    = wr_data && start_q && q_full;
      err_clr             = wr_err ? bus_wdata[ERR_W-1:0] : '0;
   end

   rcfg_err_flags #(.W(ERR_W)) u_err (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_i  (err_set),
      .clr_i  (err_clr),
      .flag_o (err_q)
   );

   always_comb begin
      ctrl_rd = '0;
      ctrl_rd[CTL_RST]                = rst_req_q;
      ctrl_rd[CTL_ACK]                = ack_q;
      ctrl_rd[CTL_RGN_LO +: RGN_W]    = region_q;
      ctrl_rd[CTL_START]              = start_q;
      ctrl_rd[CTL_DONE]               = done_q;
      stat_rd = '0;
      stat_rd[STS_CRED_W-1:0]         = credit;
      stat_rd[STS_BUSY]               = start_q;
      stat_rd[STS_CTRLR_LO +: 3]      = eng_ctrlr_sts;
      stat_rd[STS_HOST_LO +: 4]       = eng_host_sts;
      unique case (bus_addr)
         ADDR_W'(OFS_CTRL):  bus_rdata = ctrl_rd;
         ADDR_W'(OFS_STAT):  bus_rdata = stat_rd;
         ADDR_W'(OFS_ERR):   bus_rdata = {{(64 - ERR_W){1'b0}}, err_q};
         ADDR_W'(OFS_ID_HI): bus_rdata = INTF_ID_HI;
         ADDR_W'(OFS_ID_LO): bus_rdata = INTF_ID_LO;
         default:            bus_rdata = '0;
      endcase
   end

   assign unused_wdata = ^bus_wdata;

   assign eng_rst_req = rst_req_q;
   assign eng_region  = region_q;
   assign eng_session = start_q;
   assign eng_pushed  = done_q;
   assign word_valid  = !q_empty;

   AST_ACK_WITH_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      ack_q |-> rst_req_q); // R2
   AST_START_HW_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(start_q) |-> $past(rst_req_q || eng_release)); // R5
   AST_DONE_NEEDS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(done_q) |-> $past(rst_req_q || eng_release)); // R6
   AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
      rst_req_q |=> !word_valid); // R3
   AST_OVF_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_data && start_q && credit == '0) |=> err_q[ERR_OVF]); // R9
   AST_PROTO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_data && !start_q) |=> err_q[ERR_PROTO]); // R10
endmodule

// File: tb/sim_rcfg_ctrl_regs.sv
module sim_rcfg_ctrl_regs;
   localparam int CLK_PERIOD = 10;
   localparam int DEPTH = 16;
   localparam logic [63:0] ID_HI = 64'h5A17_C0DE_0000_0001;
   localparam logic [63:0] ID_LO = 64'h9E3D_44F1_BEEF_7702;
   localparam logic [7:0] A_CTRL = 8'h08, A_STAT = 8'h10, A_DATA = 8'h18,
                          A_ERR = 8'h20, A_IDH = 8'hA8, A_IDL = 8'hB0;

   logic clk = 1'b0, rst_n = 1'b0;
   logic bus_wr = 1'b0;
   logic [7:0] bus_addr = '0;
   logic [63:0] bus_wdata = '0, bus_rdata;
   logic eng_rst_req, eng_session, eng_pushed, word_valid;
   logic [2:0] eng_region;
   logic eng_release = 1'b0, eng_err_op = 1'b0, eng_err_crc = 1'b0, eng_err_incompat = 1'b0;
   logic [2:0] eng_ctrlr_sts = '0;
   logic [3:0] eng_host_sts = '0;
   logic [31:0] word_data;
   logic word_take = 1'b0;

   int n_chk = 0, n_err = 0;
   logic [31:0] mq[$];

   always #(CLK_PERIOD / 2) clk = ~clk;

   rcfg_ctrl_regs u0 (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .eng_rst_req(eng_rst_req),
      .eng_region(eng_region), .eng_session(eng_session), .eng_pushed(eng_pushed),
      .eng_release(eng_release), .eng_err_op(eng_err_op), .eng_err_crc(eng_err_crc),
      .eng_err_incompat(eng_err_incompat), .eng_ctrlr_sts(eng_ctrlr_sts),
      .eng_host_sts(eng_host_sts), .word_valid(word_valid), .word_data(word_data),
      .word_take(word_take)
   );

   function automatic logic [63:0] ctrl_val(input logic rq, input logic ak,
                                            input logic [2:0] rg, input logic st,
                                            input logic dn);
      logic [63:0] v = '0;
      v[0] = rq; v[4] = ak; v[9:7] = rg; v[12] = st; v[13] = dn;
      return v;
   endfunction

   function automatic logic [63:0] stat_val(input int cred, input logic busy,
                                            input logic [2:0] cs, input logic [3:0] hs);
      logic [63:0] v = '0;
      v[8:0] = 9'(cred); v[16] = busy; v[22:20] = cs; v[27:24] = hs;
      return v;
   endfunction

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic rd(input logic [7:0] a, output logic [63:0] d);
      bus_wr = 1'b0;
      bus_addr = a;
      #1 d = bus_rdata;
   endtask

   task automatic wr(input logic [7:0] a, input logic [63:0] d);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      tick();
      bus_wr = 1'b0;
   endtask

   initial begin : watchdog
      #(CLK_PERIOD * 150000);
      n_err++;
      $display("FAIL watchdog expired");
      $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin : main
      logic [63:0] d;
      logic [63:0] rw;
      logic do_push;
      void'($urandom(32'd4711));
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;

      // reset state
      rd(A_CTRL, d); chk("R1 ctrl reset", d, 64'h0);
      rd(A_STAT, d); chk("R7 status reset", d, stat_val(DEPTH, 0, 0, 0));
      rd(A_ERR, d);  chk("R11 err reset", d, 64'h0);
      chk("R8 no word after reset", {63'h0, word_valid}, 64'h0);

      // identifier and unmapped/read-only offsets
      rd(A_IDH, d); chk("R12 id high", d, ID_HI);
      rd(A_IDL, d); chk("R12 id low", d, ID_LO);
      rd(8'h28, d); chk("R1 unmapped reads zero", d, 64'h0);
      wr(A_IDH, '1);
      rd(A_IDH, d); chk("R1 id write ignored", d, ID_HI);
      rd(A_DATA, d); chk("R1 data offset reads zero", d, 64'h0);

      // reset handshake
      wr(A_CTRL, 64'h1);
      rd(A_CTRL, d); chk("R2 request without ack yet", d, ctrl_val(1, 0, 0, 0, 0));
      chk("R3 reset output", {63'h0, eng_rst_req}, 64'h1);
      tick();
      rd(A_CTRL, d); chk("R2 ack raised", d, ctrl_val(1, 1, 0, 0, 0));
      wr(A_CTRL, 64'h0);
      rd(A_CTRL, d); chk("R2 ack falls with request", d, 64'h0);

      // data write with no session
      wr(A_DATA, 64'h1234);
      rd(A_ERR, d);  chk("R10 protocol flag", d, 64'h8);
      rd(A_STAT, d); chk("R10 word discarded", d, stat_val(DEPTH, 0, 0, 0));
      wr(A_ERR, 64'h8);
      rd(A_ERR, d);  chk("R11 write-one clears", d, 64'h0);

      // open session for region 5
      wr(A_CTRL, ctrl_val(0, 0, 3'd5, 1, 0));
      rd(A_CTRL, d); chk("R4 R5 session open", d, ctrl_val(0, 0, 3'd5, 1, 0));
      chk("R4 region output", {61'h0, eng_region}, 64'd5);
      rd(A_STAT, d); chk("R5 busy status", d, stat_val(DEPTH, 1, 0, 0));
      wr(A_CTRL, ctrl_val(0, 0, 3'd5, 0, 0));
      rd(A_CTRL, d); chk("R5 software cannot clear start", d, ctrl_val(0, 0, 3'd5, 1, 0));

      // random push/take traffic against a model queue
      for (int i = 0; i < 400; i++) begin
         rd(A_STAT, d);
         chk("R7 credit", {55'h0, d[8:0]}, 64'(DEPTH - mq.size()));
         chk("R8 valid", {63'h0, word_valid}, {63'h0, mq.size() > 0});
         if (mq.size() > 0) chk("R8 order", {32'h0, word_data}, {32'h0, mq[0]});
         do_push = ($urandom % 2 == 1) && (DEPTH - mq.size() > 1);
         word_take = ($urandom % 3 != 0);
         rw = {$urandom, $urandom};
         if (word_take && mq.size() > 0) void'(mq.pop_front());
         if (do_push) begin
            mq.push_back(rw[31:0]);
            wr(A_DATA, rw);
         end else begin
            tick();
         end
         word_take = 1'b0;
      end

      // fill to full, then overflow
      while (mq.size() < DEPTH) begin
         rw = {$urandom, $urandom};
         mq.push_back(rw[31:0]);
         wr(A_DATA, rw);
      end
      rd(A_STAT, d); chk("R7 credit zero when full", {55'h0, d[8:0]}, 64'h0);
      wr(A_DATA, 64'hDEAD_BEEF);
      rd(A_ERR, d);  chk("R9 overflow flag", d, 64'h10);
      rd(A_STAT, d); chk("R9 credit unchanged", {55'h0, d[8:0]}, 64'h0);
      for (int i = 0; i < DEPTH; i++) begin
         chk("R9 contents kept", {32'h0, word_data}, {32'h0, mq[0]});
         void'(mq.pop_front());
         word_take = 1'b1;
         tick();
         word_take = 1'b0;
      end
      chk("R9 queue drained", {63'h0, word_valid}, 64'h0);
      wr(A_ERR, 64'h10);

      // completion and hardware release
      wr(A_CTRL, ctrl_val(0, 0, 3'd5, 1, 1));
      chk("R6 pushed output", {63'h0, eng_pushed}, 64'h1);
      eng_release = 1'b1; tick(); eng_release = 1'b0;
      rd(A_CTRL, d); chk("R5 R6 released", d, ctrl_val(0, 0, 3'd5, 0, 0));
      rd(A_STAT, d); chk("R5 idle status", d, stat_val(DEPTH, 0, 0, 0));

      // engine error flags
      eng_err_crc = 1'b1; tick(); eng_err_crc = 1'b0;
      repeat (3) tick();
      rd(A_ERR, d); chk("R11 crc sticky", d, 64'h2);
      eng_err_op = 1'b1;
      wr(A_ERR, 64'h3);
      eng_err_op = 1'b0;
      rd(A_ERR, d); chk("R11 set beats clear", d, 64'h1);
      eng_err_incompat = 1'b1; tick(); eng_err_incompat = 1'b0;
      rd(A_ERR, d); chk("R11 incompat flag", d, 64'h5);
      wr(A_ERR, 64'h1F);
      rd(A_ERR, d); chk("R11 all cleared", d, 64'h0);

      // status mirrors
      eng_ctrlr_sts = 3'd5; eng_host_sts = 4'hA;
      rd(A_STAT, d); chk("R7 status fields", d, stat_val(DEPTH, 0, 3'd5, 4'hA));
      eng_ctrlr_sts = '0; eng_host_sts = '0;

      // reset during a session flushes
      wr(A_CTRL, ctrl_val(0, 0, 3'd2, 1, 0));
      wr(A_DATA, 64'h11); wr(A_DATA, 64'h22); wr(A_DATA, 64'h33);
      rd(A_STAT, d); chk("R8 three queued", {55'h0, d[8:0]}, 64'(DEPTH - 3));
      wr(A_CTRL, ctrl_val(1, 0, 3'd2, 0, 0));
      tick();
      rd(A_CTRL, d); chk("R3 session cleared", d, ctrl_val(1, 1, 3'd2, 0, 0));
      rd(A_STAT, d); chk("R3 queue flushed", d, stat_val(DEPTH, 0, 0, 0));
      chk("R3 no valid word", {63'h0, word_valid}, 64'h0);
      wr(A_CTRL, 64'h0);
      rd(A_CTRL, d); chk("R2 released", d, 64'h0);

      $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule